// File: doc/BRIEF.md
# Display RAM Host Access Pointer

This block sits between a host byte port and a bit-mapped display memory of nine pages, each page holding 96 eight-bit columns. Page 8 is the single icon row. The host presents one byte per access, with a data/command flag and a read/write flag. Command writes move a page pointer and a 7-bit column pointer. Data writes store a byte at the addressed location. Data reads return bytes from the memory. Every data access moves the column one step, and the step after column 95 goes back to column 0. The page pointer does not move.

The memory is synchronous and takes a cycle to return data. For this reason reads are pipelined. Each data read issues a fetch at the current column and hands back the byte fetched by the read before it. The first read after the pipeline is emptied returns a dummy 0x00. A read with the command flag low returns a status byte built from three external status inputs. A software reset command and the hardware reset both return the pointers to page 0, column 0.

Top module: `gfx_ram_access`

## Requirements
- R1: While the hardware reset is held and after it is released, page and column are 0, `host_rvalid` is low and `host_rdata` is 0x00. The first data read after reset is a dummy.
- R2: Command 0000_cccc sets column bits 3:0. Command 0001_0ccc sets column bits 6:4. Command 1011_pppp sets the page when pppp is 8 or less. A page value of 9 to 15 is ignored and leaves the pipeline untouched.
- R3: A data write stores `host_wdata` at memory address page*96+column in the same cycle and advances the column.
- R4: After each data read or data write the column advances by one. Column 95, or any higher value, goes to 0, and the page is unchanged. Command writes and status reads neither advance the column nor access the memory.
- R5: Every read (data or status) gives `host_rvalid` high for exactly the next cycle, with the result on `host_rdata`. No other access raises it.
- R6: A data read returns the byte fetched by the previous data read, so reads at columns n, n+1, n+2 return dummy, byte n, byte n+1. The pipeline is emptied by any column or valid page command, by the software reset, by a data write and by the hardware reset. The first read after any of these returns 0x00.
- R7: A read with the data/command flag low returns {busy, display-on, resetting, 5'b00000}, with busy in bit 7, sampled in the request cycle. It does not disturb the read pipeline.
- R8: Command 0xE2 clears the page and column to 0 and empties the pipeline.
- R9: With the page set to 8, accesses reach the icon row at addresses 768 to 863.
- R10: An access at a column of 96 or more makes no memory access. A read fetched there yields 0x00 on the following read. The column then wraps to 0.
- R11: Any other command byte has no effect on pointers or pipeline.
- R12: Reads on consecutive cycles each return the correct pipelined byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access strobe, one access per cycle |
| host_dc | input | 1 | 1 = data access, 0 = command/status |
| host_rd | input | 1 | 1 = read, 0 = write |
| host_wdata | input | 8 | Command or data byte |
| stat_busy | input | 1 | Status bit 7 source |
| stat_disp_on | input | 1 | Status bit 6 source |
| stat_resetting | input | 1 | Status bit 5 source |
| ram_rdata | input | 8 | Memory read data, one cycle after a read enable |
| host_rdata | output | 8 | Read result |
| host_rvalid | output | 1 | Read result valid |
| ram_en | output | 1 | Memory access enable |
| ram_we | output | 1 | Memory write enable |
| ram_addr | output | ADDR_W | Memory address page*COLS+column |
| ram_wdata | output | 8 | Memory write data |

## Verification
The bench drives back-to-back reads through the 95-to-0 wrap. A design that wrapped at 127 or changed the page there would return bytes from the wrong row. It places writes, pointer commands, the software reset and unknown commands between reads. A pipeline that failed to empty would return a stale byte instead of the 0x00 dummy, and one that emptied on an ignored byte would return a dummy too many. Status reads are mixed into read streams, which catches a status path that advances the column or drops the prefetched byte. Out-of-range columns and the icon page are used to catch a fetch that wrongly reaches the memory or misses the last row.

// File: rtl/gfxa_pkg.sv
package gfxa_pkg;
  typedef enum logic [2:0] {
    PCMD_NONE,
    PCMD_COL_LO,
    PCMD_COL_HI,
    PCMD_PAGE,
    PCMD_SWRST
  } ptr_cmd_e;

  localparam logic [7:0] SWRST_BYTE = 8'hE2;
  localparam logic [7:0] DUMMY_BYTE = 8'h00;
endpackage

// File: rtl/gfxa_rst_sync.sv
module gfxa_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/gfxa_cmd_decode.sv
module gfxa_cmd_decode
  import gfxa_pkg::*;
#(
  parameter int unsigned PAGES = 9
) (
  input  logic [7:0] cmd_byte,
  output ptr_cmd_e   cmd_kind,
  output logic [3:0] cmd_arg
);
  always_comb begin
    cmd_kind = PCMD_NONE;
    cmd_arg  = cmd_byte[3:0];
    if (cmd_byte == SWRST_BYTE) begin
      cmd_kind = PCMD_SWRST;
    end else begin
      unique case (cmd_byte[7:4])
        4'h0: cmd_kind = PCMD_COL_LO;
        4'h1: cmd_kind = cmd_byte[3] ? PCMD_NONE : PCMD_COL_HI;
        4'hB: cmd_kind = (32'(cmd_byte[3:0]) < PAGES) ? PCMD_PAGE : PCMD_NONE;
        default: cmd_kind = PCMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/gfxa_addr_ptr.sv
module gfxa_addr_ptr
  import gfxa_pkg::*;
#(
  parameter int unsigned PAGES = 9,
  parameter int unsigned COLS  = 96,
  localparam int unsigned PAGE_W = $clog2(PAGES),
  localparam int unsigned COL_W  = $clog2(COLS),
  localparam int unsigned HI_W   = COL_W - 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_en,
  input  ptr_cmd_e          cmd_kind,
  input  logic [3:0]        cmd_arg,
  input  logic              adv,
  output logic [PAGE_W-1:0] page_q,
  output logic [COL_W-1:0]  col_q,
  output logic              ptr_inval
);
  logic [PAGE_W-1:0] page_d;
  logic [COL_W-1:0]  col_d;
  logic              page_en, col_en;
  logic [COL_W-1:0]  col_step;

  always_comb begin
    col_step = (32'(col_q) >= COLS - 1) ? '0 : col_q + COL_W'(1);
  end

  always_comb begin
    page_d    = page_q;
    col_d     = col_q;
    page_en   = 1'b0;
    col_en    = 1'b0;
    ptr_inval = 1'b0;
    if (cmd_en) begin
      unique case (cmd_kind)
        PCMD_COL_LO: begin
          col_d     = {col_q[COL_W-1:4], cmd_arg};
          col_en    = 1'b1;
          ptr_inval = 1'b1;
        end
        PCMD_COL_HI: begin
          col_d     = {cmd_arg[HI_W-1:0], col_q[3:0]};
          col_en    = 1'b1;
          ptr_inval = 1'b1;
        end
        PCMD_PAGE: begin
          page_d    = cmd_arg[PAGE_W-1:0];
          page_en   = 1'b1;
          ptr_inval = 1'b1;
        end
        PCMD_SWRST: begin
          page_d    = '0;
          col_d     = '0;
          page_en   = 1'b1;
          col_en    = 1'b1;
          ptr_inval = 1'b1;
        end
        default: ;
      endcase
    end else if (adv) begin
      col_d  = col_step;
      col_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      col_q  <= '0;
    end else begin
      if (page_en) page_q <= page_d;
      if (col_en)  col_q  <= col_d;
    end
  end
endmodule

// File: rtl/gfxa_read_pipe.sv
module gfxa_read_pipe
  import gfxa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_data,
  input  logic       rd_stat,
  input  logic       inval,
  input  logic       col_in,
  input  logic [7:0] ram_rdata,
  input  logic [7:0] stat_byte,
  output logic [7:0] host_rdata,
  output logic       host_rvalid
);
  logic       fetch_q, fetch_d;
  logic       oor_q, oor_d;
  logic       pv_q, pv_d;
  logic [7:0] pf_q, pf_d;
  logic [7:0] rdata_q, rdata_d;
  logic       rvalid_q, rvalid_d;
  logic       pf_en, rdata_en;
  logic [7:0] fill, cur;

  always_comb begin
    fill     = oor_q ? DUMMY_BYTE : ram_rdata;
    cur      = fetch_q ? fill : (pv_q ? pf_q : DUMMY_BYTE);
    fetch_d  = rd_data;
    oor_d    = rd_data & ~col_in;
    pf_en    = fetch_q;
    pf_d     = fill;
    if (inval)        pv_d = 1'b0;
    else if (fetch_q) pv_d = 1'b1;
    else              pv_d = pv_q;
    rdata_en = rd_data | rd_stat;
    rdata_d  = rd_data ? cur : stat_byte;
    rvalid_d = rd_data | rd_stat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q  <= 1'b0;
      oor_q    <= 1'b0;
      pv_q     <= 1'b0;
      pf_q     <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      fetch_q  <= fetch_d;
      oor_q    <= oor_d;
      pv_q     <= pv_d;
      rvalid_q <= rvalid_d;
      if (pf_en)    pf_q    <= pf_d;
      if (rdata_en) rdata_q <= rdata_d;
    end
  end

  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;
endmodule

// File: rtl/gfx_ram_access.sv
module gfx_ram_access
  import gfxa_pkg::*;
#(
  parameter int unsigned PAGES = 9,
  parameter int unsigned COLS  = 96,
  localparam int unsigned ADDR_W = $clog2(PAGES * COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_dc,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  input  logic              stat_busy,
  input  logic              stat_disp_on,
  input  logic              stat_resetting,
  input  logic [7:0]        ram_rdata,
  output logic [7:0]        host_rdata,
  output logic              host_rvalid,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata
);
  localparam int unsigned PAGE_W = $clog2(PAGES);
  localparam int unsigned COL_W  = $clog2(COLS);

  logic              rst_n_int;
  logic              is_cmd_wr, is_stat, is_dwr, is_drd, col_in;
  ptr_cmd_e          cmd_kind;
  logic [3:0]        cmd_arg;
  logic [PAGE_W-1:0] page_q;
  logic [COL_W-1:0]  col_q;
  logic              ptr_inval;
  logic [7:0]        stat_byte;

  gfxa_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  always_comb begin
    is_cmd_wr = host_valid & ~host_dc & ~host_rd;
    is_stat   = host_valid & ~host_dc &  host_rd;
    is_dwr    = host_valid &  host_dc & ~host_rd;
    is_drd    = host_valid &  host_dc &  host_rd;
    col_in    = 32'(col_q) < COLS;
    stat_byte = {stat_busy, stat_disp_on, stat_resetting, 5'b00000};
  end

  gfxa_cmd_decode #(.PAGES(PAGES)) u_dec (
    .cmd_byte (host_wdata),
    .cmd_kind (cmd_kind),
    .cmd_arg  (cmd_arg)
  );

  gfxa_addr_ptr #(.PAGES(PAGES), .COLS(COLS)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cmd_en    (is_cmd_wr),
    .cmd_kind  (cmd_kind),
    .cmd_arg   (cmd_arg),
    .adv       (is_dwr | is_drd),
    .page_q    (page_q),
    .col_q     (col_q),
    .ptr_inval (ptr_inval)
  );

  gfxa_read_pipe u_pipe (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .rd_data     (is_drd),
    .rd_stat     (is_stat),
    .inval       (ptr_inval | is_dwr),
    .col_in      (col_in),
    .ram_rdata   (ram_rdata),
    .stat_byte   (stat_byte),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid)
  );

  always_comb begin
    ram_en    = (is_dwr | is_drd) & col_in;
    ram_we    = is_dwr & col_in;
    ram_addr  = ADDR_W'(page_q) * ADDR_W'(COLS) + ADDR_W'(col_q);
    ram_wdata = host_wdata;
  end
endmodule

// File: rtl/gfxa_checker.sv
module gfxa_checker #(
  parameter int unsigned PAGES = 9,
  parameter int unsigned COLS  = 96,
  localparam int unsigned ADDR_W = $clog2(PAGES * COLS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_valid,
  input logic              host_dc,
  input logic              host_rd,
  input logic [7:0]        host_wdata,
  input logic              stat_busy,
  input logic              stat_disp_on,
  input logic              stat_resetting,
  input logic [7:0]        ram_rdata,
  input logic [7:0]        host_rdata,
  input logic              host_rvalid,
  input logic              ram_en,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [7:0]        ram_wdata
);
  p_rvalid_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_rd) |=> host_rvalid);

  p_rvalid_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_valid && host_rd) |=> !host_rvalid);

  p_status_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_rd && !host_dc) |=>
      (host_rdata == {$past(stat_busy), $past(stat_disp_on), $past(stat_resetting), 5'b00000}));

  p_cmd_no_ram_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_dc) |-> !ram_en);

  p_write_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && ram_we) |-> (host_valid && host_dc && !host_rd && ram_wdata == host_wdata));

  p_col_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en ##1 ram_en |->
      (({1'b0, ram_addr}) == ({1'b0, $past(ram_addr)} + 1) ||
       ({1'b0, ram_addr} + (ADDR_W+1)'(COLS - 1)) == {1'b0, $past(ram_addr)}));

  p_dummy_after_swrst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_dc && !host_rd && host_wdata == 8'hE2) ##1
    (host_valid && host_dc && host_rd) |=> (host_rdata == 8'h00));

  p_addr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> (32'(ram_addr) < PAGES * COLS));
endmodule

bind gfx_ram_access gfxa_checker #(.PAGES(PAGES), .COLS(COLS)) i_chk (.*);

// File: tb/test_gfx_ram_access.sv
module test_gfx_ram_access;
  localparam int PAGES = 9;
  localparam int COLS  = 96;
  localparam int NW    = PAGES * COLS;
  localparam int AW    = $clog2(NW);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          host_valid, host_dc, host_rd;
  logic [7:0]    host_wdata;
  logic          stat_busy, stat_disp_on, stat_resetting;
  logic [7:0]    ram_rdata;
  logic [7:0]    host_rdata;
  logic          host_rvalid;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [7:0]    ram_wdata;

  gfx_ram_access #(.PAGES(PAGES), .COLS(COLS)) i_gfx_ram_access (.*);

  logic [7:0] ram_arr [NW];
  logic [7:0] mmem [NW];

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) ram_arr[ram_addr] <= ram_wdata;
      else        ram_rdata <= ram_arr[ram_addr];
    end
  end

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  int mpage, mcol;
  bit mpv;
  logic [7:0] mpf;
  bit pend;
  logic [7:0] pend_exp;
  string pend_tag;

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic int next_col(int c);
    return (c >= COLS - 1) ? 0 : c + 1;
  endfunction

  function automatic int maddr();
    return mpage * COLS + mcol;
  endfunction

  task automatic step(bit v, bit dc, bit rd, logic [7:0] d, string tag);
    @(negedge clk);
    check8("R5 rvalid", {7'd0, host_rvalid}, {7'd0, pend});
    if (pend) check8(pend_tag, host_rdata, pend_exp);
    pend = 0;
    host_valid     = v;
    host_dc        = dc;
    host_rd        = rd;
    host_wdata     = d;
    stat_busy      = 1'($urandom);
    stat_disp_on   = 1'($urandom);
    stat_resetting = 1'($urandom);
    if (v) begin
      if (!dc && !rd) begin
        if (d == 8'hE2) begin
          mpage = 0; mcol = 0; mpv = 0;
        end else if (d[7:4] == 4'h0) begin
          mcol = (mcol & 'h70) | int'(d[3:0]); mpv = 0;
        end else if (d[7:4] == 4'h1 && !d[3]) begin
          mcol = (int'(d[2:0]) << 4) | (mcol & 'hF); mpv = 0;
        end else if (d[7:4] == 4'hB && d[3:0] <= 4'd8) begin
          mpage = int'(d[3:0]); mpv = 0;
        end
      end else if (!dc && rd) begin
        pend = 1; pend_tag = tag;
        pend_exp = {stat_busy, stat_disp_on, stat_resetting, 5'b0};
      end else if (dc && !rd) begin
        if (mcol < COLS) mmem[maddr()] = d;
        mpv = 0;
        mcol = next_col(mcol);
      end else begin
        pend = 1; pend_tag = tag;
        pend_exp = mpv ? mpf : 8'h00;
        mpf = (mcol < COLS) ? mmem[maddr()] : 8'h00;
        mpv = 1;
        mcol = next_col(mcol);
      end
    end
  endtask

  task automatic cmd(logic [7:0] d, string tag);  step(1, 0, 0, d, tag); endtask
  task automatic wr(logic [7:0] d, string tag);   step(1, 1, 0, d, tag); endtask
  task automatic rd(string tag);                  step(1, 1, 1, 8'h00, tag); endtask
  task automatic srd(string tag);                 step(1, 0, 1, 8'h00, tag); endtask
  task automatic idle();                          step(0, 0, 0, 8'h00, "idle"); endtask
  task automatic set_col(int c, string tag);
    cmd(8'(c & 'hF), tag);
    cmd(8'h10 | 8'((c >> 4) & 7), tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NW; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      ram_arr[i] = v;
      mmem[i] = v;
    end
    mpage = 0; mcol = 0; mpv = 0; mpf = 8'h00; pend = 0;
    host_valid = 0; host_dc = 0; host_rd = 0; host_wdata = 0;
    stat_busy = 0; stat_disp_on = 0; stat_resetting = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check8("R1 rvalid in reset", {7'd0, host_rvalid}, 8'h00);
    check8("R1 rdata in reset", host_rdata, 8'h00);
    rst_n = 1;
    repeat (4) @(posedge clk);
    check8("R1 rdata after reset", host_rdata, 8'h00);

    // R1: first read is a dummy, then column 0 of page 0
    rd("R1 dummy"); rd("R1 first byte"); rd("R12 back-to-back");
    // R2: compose column 0x25 on page 3
    cmd(8'h05, "R2"); cmd(8'h12, "R2"); cmd(8'hB3, "R2");
    rd("R6 dummy after set"); rd("R2 col 37 page 3"); rd("R12");
    // R2: invalid page ignored, pipeline kept
    cmd(8'hB9, "R2"); rd("R2 page 9 ignored"); rd("R2");
    // R11: unknown command keeps pipeline and column
    cmd(8'hA8, "R11"); rd("R11 no effect"); cmd(8'h18, "R11"); rd("R11 no effect");
    // R3 / R6: write invalidates, readback
    set_col(20, "R3"); wr(8'hA5, "R3"); wr(8'h3C, "R3");
    rd("R6 dummy after write"); rd("R3"); set_col(20, "R3");
    rd("R6"); rd("R3 readback a5"); rd("R3 readback 3c");
    // R4 / R7: wrap at 95 with page kept, status reads in between
    cmd(8'hB1, "R4"); set_col(95, "R4");
    wr(8'h77, "R4"); wr(8'h88, "R4"); set_col(94, "R4");
    rd("R6"); srd("R7 status"); rd("R4 col 94"); srd("R7 status");
    rd("R4 col 95"); rd("R4 wrap to col 0"); rd("R4 col 1");
    // R9: icon row
    cmd(8'hB8, "R9"); set_col(95, "R9"); wr(8'h5A, "R9"); wr(8'hC3, "R9");
    set_col(95, "R9"); rd("R9"); rd("R9 icon col 95"); rd("R9 icon col 0");
    // R10: columns beyond the row
    set_col(127, "R10"); wr(8'hEE, "R10"); rd("R10 dummy"); rd("R10 col 0 after wrap");
    set_col(100, "R10"); rd("R10"); rd("R10 oor fetch gives 00"); rd("R10 col 0");
    // R8: software reset
    cmd(8'hB5, "R8"); set_col(40, "R8"); rd("R8"); rd("R8");
    cmd(8'hE2, "R8"); rd("R8 dummy after swrst"); rd("R8 page 0 col 0");

    for (int k = 0; k < 4000; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if      (r < 12) cmd(8'($urandom_range(0, 15)), "R2 random col lo");
      else if (r < 20) cmd(8'h10 | 8'($urandom_range(0, 15)), "R2 random col hi");
      else if (r < 27) cmd(8'hB0 | 8'($urandom_range(0, 15)), "R2 random page");
      else if (r < 29) cmd(8'hE2, "R8 random");
      else if (r < 32) cmd(8'($urandom), "R11 random cmd");
      else if (r < 55) wr(8'($urandom), "R3 random");
      else if (r < 85) rd("R6 random read");
      else if (r < 92) srd("R7 random status");
      else idle();
    end
    idle(); idle();
    summary();
  end
endmodule